// File: doc/BRIEF.md
# Burst PSRAM Device-Side Sequencer

This block is the memory side of a synchronous pseudo-static RAM that shares one bus for address and data. The address is taken in a single clock edge from the shared 16-bit bus plus four upper address pins. The block then waits out a configured access latency and steps a burst address counter through a small internal word array. A WAIT pin tells the controller in which cycles a word actually moves. Reads drive the shared bus during those cycles. Writes take the bus value, with per-byte enables.

Burst length, wrap-within-burst, latency code, fixed or variable read latency and WAIT polarity come from configuration inputs. The first four are taken at address capture. Linear bursts stall with WAIT for a fixed number of cycles after leaving the last word of a 128-word row. Continuous bursts run to the top of the modelled space and then resume at the address they started from. Deselecting the chip ends any burst at once. A new address strobe starts a new burst from any state.

Top module: `psram_burst_seq`

## Requirements
- R1: The burst length code `cfgBurstLen` 0, 1, 2 or 3 gives a fixed burst of 4, 8, 16 or 32 words. After exactly that many transfers, WAIT stays active and the bus is not driven until `ceN` goes high.
- R2: On a rising edge with `ceN` and `advN` both low, the block captures the address `{addrHi, adqIn}` and takes a write when `weN` is low. Only the low 8 bits select a word, so addresses that differ only above bit 7 reach the same word.
- R3: For writes and for reads with `cfgVarLat`=0, the first transfer happens in cycle code+1 after the capture edge. Here code is `cfgLatCode`. WAIT is active in every cycle before it, and the word moves on the edge that ends that cycle.
- R4: For reads with `cfgVarLat`=1, the first transfer happens in cycle `cfgLatCode` after the capture edge, and never earlier than cycle 1.
- R5: With `cfgWrapOn`=1 and a fixed length N, the word address steps through the N-aligned block that holds the start address, wrapping inside it. No row stall occurs.
- R6: When a burst is linear (wrap off, or a continuous length), a transfer of a word whose low 7 address bits are all ones is followed by exactly 2 cycles of active WAIT before the next transfer. This does not apply when that word ends a fixed burst.
- R7: Length codes 4 to 7 select a continuous burst. Its address counts up by one, and after word 0xFF it returns to the start address.
- R8: During a read transfer cycle `adqOe` is 1 and `adqOut` holds the addressed word. In every wait cycle and in every write cycle, `adqOe` is 0.
- R9: In a write transfer cycle, the edge ending the cycle stores `adqIn[7:0]` when `lbN` is low and `adqIn[15:8]` when `ubN` is low. A lane whose enable is high keeps its old value.
- R10: With `cfgWaitActHigh`=1 the WAIT pin is high when active; with 0 it is low when active. While `ceN` is high, the pin sits at its inactive level.
- R11: Raising `ceN` during a burst drops `adqOe` in the same cycle. The next burst starts normally.
- R12: After reset the block is idle, `adqOe` is 0, WAIT is inactive and every stored word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip select, active low |
| advN | input | 1 | Address-valid strobe, active low |
| weN | input | 1 | Write select at address capture, active low |
| lbN | input | 1 | Low byte lane write enable, active low |
| ubN | input | 1 | High byte lane write enable, active low |
| addrHi | input | 4 | Upper address bits |
| adqIn | input | 16 | Shared bus input: low address bits, then write data |
| adqOut | output | 16 | Read data driven onto the shared bus |
| adqOe | output | 1 | Bus output enable for read data |
| waitOut | output | 1 | WAIT pin, polarity set by cfgWaitActHigh |
| cfgBurstLen | input | 3 | Burst length code (0-3 fixed 4/8/16/32, 4-7 continuous) |
| cfgWrapOn | input | 1 | Wrap within a fixed burst |
| cfgLatCode | input | 3 | Latency code |
| cfgVarLat | input | 1 | Variable latency for reads |
| cfgWaitActHigh | input | 1 | WAIT active level is high |

## Verification
A wrong latency counter shifts the first cleared WAIT cycle. This shows in the very first burst as a WAIT level mismatch in cycle code+1, or as read data one word off. A corrupted burst address counter or a bad wrap mask shows on the first read-back of a word that a write placed elsewhere. A missed row stall shows as WAIT clear in the cycle right after the row's last word. A bad word count shows as WAIT staying clear after the last word of a fixed burst. Because every read is compared with a bench memory image, a lane-enable fault appears on the next read of the touched word.

// File: rtl/psram_burst_pkg.sv
package psram_burst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAT,
    ST_XFER,
    ST_STALL,
    ST_DONE
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic step;
    logic wrEn;
  } seqStrobe_t;

  function automatic logic [5:0] burstWords(input logic [1:0] lenCode);
    return 6'd4 << lenCode;
  endfunction

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import psram_burst_pkg::*;
#(
  parameter int LAT_W     = 3,
  parameter int ROW_STALL = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceN,
  input  logic             advN,
  input  logic             weN,
  input  logic [2:0]       cfgBurstLen,
  input  logic             cfgWrapOn,
  input  logic [LAT_W-1:0] cfgLatCode,
  input  logic             cfgVarLat,
  input  logic             rowEnd,
  output seqStrobe_t       stb,
  output logic             waitActive,
  output logic             driveRead
);

  localparam int LAT_MAX = 1 << LAT_W;
  localparam int CNT_MAX = (ROW_STALL > LAT_MAX) ? ROW_STALL : LAT_MAX;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  seqState_t        state;
  logic [CNT_W-1:0] waitCnt;
  logic [5:0]       wordsLeft;
  logic             contMode;
  logic             wrapFixed;
  logic             isWrite;
  logic [CNT_W-1:0] latTotal;
  logic             stallNeeded;

  always_comb begin
    latTotal = CNT_W'(cfgLatCode);
    if (!weN || !cfgVarLat) latTotal = latTotal + CNT_W'(1);
    if (latTotal == '0) latTotal = CNT_W'(1);
  end

  assign stallNeeded = rowEnd && !wrapFixed && (ROW_STALL != 0);

  assign stb.capture = !ceN && !advN;
  assign stb.step    = !ceN && advN && (state == ST_XFER);
  assign stb.wrEn    = stb.step && isWrite;

  assign waitActive = !ceN &&
                      (state == ST_LAT || state == ST_STALL || state == ST_DONE);
  assign driveRead  = !ceN && !isWrite && (state == ST_XFER);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      waitCnt   <= '0;
      wordsLeft <= '0;
      contMode  <= 1'b0;
      wrapFixed <= 1'b0;
      isWrite   <= 1'b0;
    end else if (ceN) begin
      state <= ST_IDLE;
    end else if (!advN) begin
      isWrite   <= !weN;
      contMode  <= cfgBurstLen[2];
      wrapFixed <= cfgWrapOn && !cfgBurstLen[2];
      wordsLeft <= burstWords(cfgBurstLen[1:0]);
      if (latTotal == CNT_W'(1)) begin
        state <= ST_XFER;
      end else begin
        state   <= ST_LAT;
        waitCnt <= latTotal - CNT_W'(1);
      end
    end else begin
      case (state)
        ST_LAT, ST_STALL: begin
          if (waitCnt == CNT_W'(1)) state <= ST_XFER;
          else waitCnt <= waitCnt - CNT_W'(1);
        end
        ST_XFER: begin
          if (!contMode) wordsLeft <= wordsLeft - 6'd1;
          if (!contMode && wordsLeft == 6'd1) begin
            state <= ST_DONE;
          end else if (stallNeeded) begin
            state   <= ST_STALL;
            waitCnt <= CNT_W'(ROW_STALL);
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import psram_burst_pkg::*;
#(
  parameter int MEM_AW = 8,
  parameter int ROW_AW = 7,
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqStrobe_t            stb,
  input  logic [2:0]            cfgBurstLen,
  input  logic                  cfgWrapOn,
  input  logic [MEM_AW-1:0]     addrIn,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [DATA_W/8-1:0]   laneEnN,
  output logic [DATA_W-1:0]     rdData,
  output logic                  rowEnd,
  output logic [MEM_AW-1:0]     curAddr
);

  localparam int MEM_WORDS = 1 << MEM_AW;
  localparam int LANES     = DATA_W / 8;

  logic [MEM_AW-1:0] startAddr;
  logic [MEM_AW-1:0] wrapMask;
  logic              wrapFixed;
  logic [MEM_AW-1:0] incAddr;
  logic [MEM_AW-1:0] nextAddr;

  assign incAddr = curAddr + MEM_AW'(1);
  assign rowEnd  = &curAddr[ROW_AW-1:0];

  always_comb begin
    if (wrapFixed)
      nextAddr = (curAddr & ~wrapMask) | (incAddr & wrapMask);
    else if (&curAddr)
      nextAddr = startAddr;
    else
      nextAddr = incAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      startAddr <= '0;
      wrapMask  <= '0;
      wrapFixed <= 1'b0;
    end else if (stb.capture) begin
      curAddr   <= addrIn;
      startAddr <= addrIn;
      wrapMask  <= MEM_AW'(burstWords(cfgBurstLen[1:0]) - 6'd1);
      wrapFixed <= cfgWrapOn && !cfgBurstLen[2];
    end else if (stb.step) begin
      curAddr <= nextAddr;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [7:0] laneMem [MEM_WORDS];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < MEM_WORDS; i++) laneMem[i] <= '0;
      end else if (stb.wrEn && !laneEnN[g]) begin
        laneMem[curAddr] <= wrData[g*8 +: 8];
      end
    end

    assign rdData[g*8 +: 8] = laneMem[curAddr];
  end

endmodule

// File: rtl/psram_burst_seq.sv
module psram_burst_seq
  import psram_burst_pkg::*;
#(
  parameter int MEM_AW    = 8,
  parameter int ROW_AW    = 7,
  parameter int LAT_W     = 3,
  parameter int ROW_STALL = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceN,
  input  logic             advN,
  input  logic             weN,
  input  logic             lbN,
  input  logic             ubN,
  input  logic [3:0]       addrHi,
  input  logic [15:0]      adqIn,
  output logic [15:0]      adqOut,
  output logic             adqOe,
  output logic             waitOut,
  input  logic [2:0]       cfgBurstLen,
  input  logic             cfgWrapOn,
  input  logic [LAT_W-1:0] cfgLatCode,
  input  logic             cfgVarLat,
  input  logic             cfgWaitActHigh
);

  localparam int DATA_W = 16;
  localparam int ADDR_W = 20;

  seqStrobe_t        stb;
  logic              waitActive;
  logic              driveRead;
  logic              rowEnd;
  logic [MEM_AW-1:0] curAddr;
  logic [DATA_W-1:0] rdData;
  logic [ADDR_W-1:0] fullAddr;
  logic [MEM_AW-1:0] memAddr;
  logic              stepStb;
  logic              unusedAddrBits;

  assign fullAddr       = {addrHi, adqIn};
  assign memAddr        = fullAddr[MEM_AW-1:0];
  assign unusedAddrBits = ^fullAddr[ADDR_W-1:MEM_AW];
  assign stepStb        = stb.step;

  burst_ctrl #(
    .LAT_W    (LAT_W),
    .ROW_STALL(ROW_STALL)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .ceN        (ceN),
    .advN       (advN),
    .weN        (weN),
    .cfgBurstLen(cfgBurstLen),
    .cfgWrapOn  (cfgWrapOn),
    .cfgLatCode (cfgLatCode),
    .cfgVarLat  (cfgVarLat),
    .rowEnd     (rowEnd),
    .stb        (stb),
    .waitActive (waitActive),
    .driveRead  (driveRead)
  );

  burst_datapath #(
    .MEM_AW(MEM_AW),
    .ROW_AW(ROW_AW),
    .DATA_W(DATA_W)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .cfgBurstLen(cfgBurstLen),
    .cfgWrapOn  (cfgWrapOn),
    .addrIn     (memAddr),
    .wrData     (adqIn),
    .laneEnN    ({ubN, lbN}),
    .rdData     (rdData),
    .rowEnd     (rowEnd),
    .curAddr    (curAddr)
  );

  assign adqOe   = driveRead;
  assign adqOut  = driveRead ? rdData : '0;
  assign waitOut = cfgWaitActHigh ? waitActive : !waitActive;

endmodule

// File: rtl/psram_burst_chk.sv
module psram_burst_chk
  import psram_burst_pkg::*;
#(
  parameter int MEM_AW = 8,
  parameter int LAT_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              advN,
  input logic              weN,
  input logic [2:0]        cfgBurstLen,
  input logic              cfgWrapOn,
  input logic [LAT_W-1:0]  cfgLatCode,
  input logic              cfgVarLat,
  input logic              cfgWaitActHigh,
  input logic              waitOut,
  input logic              adqOe,
  input logic [MEM_AW-1:0] capAddr,
  input logic [MEM_AW-1:0] curAddr,
  input logic              stepStb
);

  logic              waitAct;
  logic              capture;
  logic [MEM_AW-1:0] startA;
  logic [MEM_AW-1:0] maskA;
  logic [5:0]        fixedLen;
  logic              isFixed;
  logic              isWrap;
  logic [6:0]        xferCnt;

  assign waitAct = cfgWaitActHigh ? waitOut : !waitOut;
  assign capture = !ceN && !advN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startA   <= '0;
      maskA    <= '0;
      fixedLen <= '0;
      isFixed  <= 1'b0;
      isWrap   <= 1'b0;
      xferCnt  <= '0;
    end else if (capture) begin
      startA   <= capAddr;
      maskA    <= MEM_AW'(burstWords(cfgBurstLen[1:0]) - 6'd1);
      fixedLen <= burstWords(cfgBurstLen[1:0]);
      isFixed  <= !cfgBurstLen[2];
      isWrap   <= cfgWrapOn;
      xferCnt  <= '0;
    end else if (stepStb && xferCnt != 7'h7F) begin
      xferCnt <= xferCnt + 7'd1;
    end
  end

  // R3: fixed latency above one clock starts with WAIT active
  assert_first_wait_R3: assert property (@(posedge clk) disable iff (!rstN)
    (capture && (!weN || !cfgVarLat) && cfgLatCode != '0) |=> (ceN || waitAct));

  // R4: variable read latency of one clock drives data in the first cycle
  assert_var_lat_R4: assert property (@(posedge clk) disable iff (!rstN)
    (capture && weN && cfgVarLat && cfgLatCode <= LAT_W'(1)) |=> (ceN || adqOe));

  // R1: a fixed burst never moves more words than its length
  assert_len_limit_R1: assert property (@(posedge clk) disable iff (!rstN)
    isFixed |-> (xferCnt <= {1'b0, fixedLen}));

  // R5: wrapped fixed bursts stay inside the aligned block
  assert_wrap_block_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stepStb && isFixed && isWrap) |-> ((curAddr & ~maskA) == (startA & ~maskA)));

  // R7: linear bursts leaving the top word resume at the start address
  assert_mem_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stepStb && !(isFixed && isWrap) && (&curAddr)) |=> (curAddr == startA));

  // R11: the bus is only driven after a cycle with the chip selected
  assert_oe_select_R11: assert property (@(posedge clk) disable iff (!rstN)
    adqOe |-> $past(!ceN));

  // R10: deselected chip shows the inactive WAIT level
  assert_idle_wait_R10: assert property (@(posedge clk) disable iff (!rstN)
    ceN |-> (waitOut == !cfgWaitActHigh));

endmodule

bind psram_burst_seq psram_burst_chk #(
  .MEM_AW(MEM_AW),
  .LAT_W (LAT_W)
) uChk (
  .clk           (clk),
  .rstN          (rstN),
  .ceN           (ceN),
  .advN          (advN),
  .weN           (weN),
  .cfgBurstLen   (cfgBurstLen),
  .cfgWrapOn     (cfgWrapOn),
  .cfgLatCode    (cfgLatCode),
  .cfgVarLat     (cfgVarLat),
  .cfgWaitActHigh(cfgWaitActHigh),
  .waitOut       (waitOut),
  .adqOe         (adqOe),
  .capAddr       (memAddr),
  .curAddr       (curAddr),
  .stepStb       (stepStb)
);

// File: tb/tb_psram_burst_seq.sv
module tb_psram_burst_seq;

  logic        clk = 1'b0;
  logic        rstN;
  logic        ceN;
  logic        advN;
  logic        weN;
  logic        lbN;
  logic        ubN;
  logic [3:0]  addrHi;
  logic [15:0] adqIn;
  logic [15:0] adqOut;
  logic        adqOe;
  logic        waitOut;
  logic [2:0]  cfgBurstLen;
  logic        cfgWrapOn;
  logic [2:0]  cfgLatCode;
  logic        cfgVarLat;
  logic        cfgWaitActHigh;

  int nChecks = 0;
  int nFails  = 0;
  logic [15:0] model [256];

  logic [19:0] rAddr;
  logic [2:0]  rLen;
  logic [2:0]  rCode;
  logic [7:0]  rLow;
  int          rWords;

  always #4 clk = ~clk;

  psram_burst_seq dut (
    .clk           (clk),
    .rstN          (rstN),
    .ceN           (ceN),
    .advN          (advN),
    .weN           (weN),
    .lbN           (lbN),
    .ubN           (ubN),
    .addrHi        (addrHi),
    .adqIn         (adqIn),
    .adqOut        (adqOut),
    .adqOe         (adqOe),
    .waitOut       (waitOut),
    .cfgBurstLen   (cfgBurstLen),
    .cfgWrapOn     (cfgWrapOn),
    .cfgLatCode    (cfgLatCode),
    .cfgVarLat     (cfgVarLat),
    .cfgWaitActHigh(cfgWaitActHigh)
  );

  function automatic logic waitOn();
    return cfgWaitActHigh ? waitOut : !waitOut;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runBurst(input bit wr, input logic [19:0] addr, input logic [2:0] len,
                          input bit wrap, input logic [2:0] code, input bit varLat,
                          input bit polHigh, input int maxWords, input string tag);
    int         lat;
    int         full;
    int         nWords;
    logic [7:0] mask;
    logic [7:0] a;
    logic [7:0] start;
    bit         wrapFixed;
    bit         stallNow;
    logic [15:0] d;
    logic [1:0] ln;
    string      latTag;
    @(negedge clk);
    cfgBurstLen = len; cfgWrapOn = wrap; cfgLatCode = code;
    cfgVarLat = varLat; cfgWaitActHigh = polHigh;
    ceN = 1'b0; advN = 1'b0; weN = !wr;
    addrHi = addr[19:16]; adqIn = addr[15:0];
    lat = (wr || !varLat) ? int'(code) + 1 : ((code == 3'd0) ? 1 : int'(code));
    latTag = (wr || !varLat) ? "R3" : "R4";
    full = 4 << len[1:0];
    nWords = len[2] ? maxWords : ((maxWords < full) ? maxWords : full);
    mask = 8'(full - 1);
    wrapFixed = wrap && !len[2];
    a = addr[7:0];
    start = a;
    @(negedge clk);
    advN = 1'b1; weN = 1'b1; adqIn = 16'($urandom);
    #1;
    for (int i = 1; i < lat; i++) begin
      chk(latTag, "WAIT active during latency", waitOn(), 1);
      chk("R8", "no drive during latency", adqOe, 0);
      @(negedge clk); #1;
    end
    for (int w = 0; w < nWords; w++) begin
      chk((w == 0) ? latTag : tag, "WAIT clear in transfer", waitOn(), 0);
      if (wr) begin
        d = 16'($urandom);
        ln = 2'($urandom);
        adqIn = d; lbN = ln[0]; ubN = ln[1];
        chk("R8", "no drive in write cycle", adqOe, 0);
        if (!ln[0]) model[a][7:0]  = d[7:0];
        if (!ln[1]) model[a][15:8] = d[15:8];
      end else begin
        chk("R8", "drive in read cycle", adqOe, 1);
        chk(tag, "read word", adqOut, model[a]);
      end
      stallNow = !wrapFixed && (a[6:0] == 7'h7F);
      if (wrapFixed) a = (a & ~mask) | ((a + 8'd1) & mask);
      else a = (a == 8'hFF) ? start : a + 8'd1;
      @(negedge clk); #1;
      if (stallNow && w != nWords - 1) begin
        for (int s = 0; s < 2; s++) begin
          chk("R6", "row stall WAIT", waitOn(), 1);
          chk("R8", "no drive in stall", adqOe, 0);
          @(negedge clk); #1;
        end
      end
    end
    if (!len[2] && nWords == full) begin
      chk("R1", "WAIT after last word", waitOn(), 1);
      chk("R1", "no drive after last word", adqOe, 0);
    end
    ceN = 1'b1; lbN = 1'b1; ubN = 1'b1;
    #1;
    chk("R11", "drive dropped on deselect", adqOe, 0);
    chk("R10", "idle WAIT level", waitOut, !polHigh);
  endtask

  initial begin
    #(8 * 200000);
    nFails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < 256; i++) model[i] = '0;
    rstN = 1'b0; ceN = 1'b1; advN = 1'b1; weN = 1'b1; lbN = 1'b1; ubN = 1'b1;
    addrHi = '0; adqIn = '0;
    cfgBurstLen = 3'd0; cfgWrapOn = 1'b0; cfgLatCode = 3'd2;
    cfgVarLat = 1'b0; cfgWaitActHigh = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk("R12", "reset bus drive", adqOe, 0);
    chk("R12", "reset WAIT level", waitOut, 1);

    // R12: memory reads zero after reset
    runBurst(1'b0, 20'h00040, 3'd0, 1'b0, 3'd2, 1'b0, 1'b0, 64, "R12");
    // R6: linear write/read across the row boundary at 0x7F
    runBurst(1'b1, 20'h0007E, 3'd1, 1'b0, 3'd2, 1'b0, 1'b0, 64, "R9");
    runBurst(1'b0, 20'h0007E, 3'd1, 1'b0, 3'd2, 1'b0, 1'b0, 64, "R6");
    // R5: wrap inside a 4-word block at the row end, no stall
    runBurst(1'b1, 20'h0007D, 3'd0, 1'b1, 3'd1, 1'b0, 1'b0, 64, "R5");
    runBurst(1'b0, 20'h0007C, 3'd0, 1'b1, 3'd1, 1'b0, 1'b0, 64, "R5");
    runBurst(1'b0, 20'h0006D, 3'd2, 1'b1, 3'd3, 1'b0, 1'b0, 64, "R5");
    // R7: continuous bursts pass the top word and return to the start
    runBurst(1'b1, 20'h000FC, 3'd4, 1'b0, 3'd2, 1'b0, 1'b0, 9, "R7");
    runBurst(1'b0, 20'h000FA, 3'd7, 1'b1, 3'd2, 1'b0, 1'b0, 14, "R7");
    // R4: variable read latency, including code 0 and code 3
    runBurst(1'b0, 20'h000FC, 3'd0, 1'b0, 3'd0, 1'b1, 1'b0, 64, "R4");
    runBurst(1'b0, 20'h000FC, 3'd0, 1'b0, 3'd3, 1'b1, 1'b0, 64, "R4");
    // R3: writes ignore the variable-latency setting
    runBurst(1'b1, 20'h00030, 3'd0, 1'b0, 3'd3, 1'b1, 1'b0, 64, "R9");
    runBurst(1'b0, 20'h00030, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 64, "R3");
    // R10: active-high WAIT
    runBurst(1'b0, 20'h00030, 3'd1, 1'b0, 3'd4, 1'b0, 1'b1, 64, "R10");
    // R11: deselect in the middle of a 32-word burst, then a fresh burst
    runBurst(1'b0, 20'h00010, 3'd3, 1'b0, 3'd2, 1'b0, 1'b0, 5, "R11");
    runBurst(1'b0, 20'h00010, 3'd0, 1'b0, 3'd2, 1'b0, 1'b0, 64, "R11");
    // R2: upper address bits alias onto the same word
    runBurst(1'b1, 20'hABC12, 3'd0, 1'b0, 3'd1, 1'b0, 1'b0, 64, "R9");
    runBurst(1'b0, 20'h00012, 3'd0, 1'b0, 3'd1, 1'b0, 1'b0, 64, "R2");

    for (int n = 0; n < 80; n++) begin
      rLow = 8'($urandom);
      case ($urandom % 3)
        0: rLow = 8'h78 | 8'($urandom % 8);
        1: rLow = 8'hF8 | 8'($urandom % 8);
        default: ;
      endcase
      rAddr = {20'($urandom) & 20'hFFF00} | {12'd0, rLow};
      rLen = 3'($urandom);
      rCode = 3'($urandom % 7);
      rWords = ($urandom % 6 == 0) ? int'($urandom % 5) + 1 : int'($urandom % 40) + 1;
      runBurst(1'($urandom), rAddr, rLen, 1'($urandom), rCode, 1'($urandom),
               1'($urandom), rWords, "R9");
    end

    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule